// File: doc/BRIEF.md
# UART Interrupt Identification Controller

This block watches the receive path, the line-error events and the transmit-empty status of a 16550-style UART. It keeps one pending flag for each interrupt source, ranks the enabled ones and reports the winner as a 4-bit identification code. A single request line goes to the interrupt controller. Each source is cleared by its own event: a register read, a character written or read, or a change in the receive FIFO level.

The receive side has two modes. Outside FIFO mode, one held character raises data-ready. In FIFO mode, data-ready follows the FIFO level against a programmable trigger. An idle timer counts baud ticks and raises the receiver timeout when characters sit unread in the FIFO. The serial shifters, the FIFOs and the bus decode live elsewhere and reach this block only as strobes and levels.

Top module: `uart_irq_id`

## Requirements
- R1: After reset, and whenever no enabled source is pending, `iid_o` is 4'b0001 and `irq_o` is low.
- R2: A pulse on `ovr_i` makes the line-status source pending, reported as 4'b0110. It clears on the cycle after an `lsr_rd_i` strobe, unless errored characters remain.
- R3: Each `rx_wr_i` with `rx_wr_err_i` high adds one errored character, and each `rx_rd_i` with `rx_rd_err_i` high removes one. The line-status code 4'b0110 stays reported while the count is non-zero, and a line-status register read does not clear it.
- R4: With `fifo_en_i` low, `rx_wr_i` sets data-ready (code 4'b0100) and `rx_rd_i` clears it.
- R5: With `fifo_en_i` high, data-ready is reported while `rx_lvl_i >= rx_trig_i` and drops as soon as the level falls below the trigger.
- R6: With `fifo_en_i` high and `rx_lvl_i` non-zero, 40 baud ticks (four 10-tick characters) with no `rx_rd_i` or `rx_wr_i` raise the receiver timeout, code 4'b1100. After 39 such ticks it is not yet reported.
- R7: Any `rx_rd_i` or `rx_wr_i` clears the receiver timeout and restarts the 40-tick count from zero.
- R8: With `fifo_en_i` low, the receiver timeout is never reported.
- R9: A rising edge of `thr_empty_i` while `ien_thre_i` is high makes the transmit-empty source pending (code 4'b0010). A `thr_wr_i` strobe clears it.
- R10: An `iir_rd_i` strobe clears the transmit-empty source only when 4'b0010 is the code being reported. An identification read while another code is shown leaves it pending.
- R11: Priority from highest to lowest is line status (0110), receiver timeout (1100), data-ready (0100), transmit-empty (0010).
- R12: A source whose enable is low is not reported. The timeout is gated by `ien_rda_i`. `irq_o` is high exactly when some enabled source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | FIFO mode enable |
| ien_rls_i | input | 1 | Line-status interrupt enable |
| ien_rda_i | input | 1 | Data-ready and timeout interrupt enable |
| ien_thre_i | input | 1 | Transmit-empty interrupt enable |
| baud_tick_i | input | 1 | One pulse per bit period |
| ovr_i | input | 1 | Overrun event pulse |
| rx_wr_i | input | 1 | Character written into the receive buffer/FIFO |
| rx_wr_err_i | input | 1 | Written character carries parity, framing or break error |
| rx_rd_i | input | 1 | Receive buffer read (FIFO pop) |
| rx_rd_err_i | input | 1 | Character being read carries an error flag |
| rx_lvl_i | input | LVL_W | Receive FIFO fill level |
| rx_trig_i | input | LVL_W | Receive FIFO trigger level |
| thr_empty_i | input | 1 | Transmit holding register / FIFO empty |
| thr_wr_i | input | 1 | Transmit holding register write |
| lsr_rd_i | input | 1 | Line status register read |
| iir_rd_i | input | 1 | Identification register read |
| iid_o | output | 4 | Identification code |
| irq_o | output | 1 | Interrupt request |

## Verification
Overrun and errored-character patterns are applied separately, so the bench can tell the clear-on-status-read path from the clear-on-last-errored-read path. Fill levels just below, at and above the trigger check the level compare. Idle windows of 39 and 40 ticks, and a window broken by a FIFO access, check the timeout threshold and its restart. Several sources are stacked at once and their enables are dropped one at a time, which checks the priority order. Identification reads are issued both while transmit-empty is shown and while a higher source hides it, so the bench can tell whether that clear depends on the reported code.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [3:0] {
    IID_NONE = 4'b0001,
    IID_THRE = 4'b0010,
    IID_RDA  = 4'b0100,
    IID_RLS  = 4'b0110,
    IID_RTO  = 4'b1100
  } iid_e;
endpackage

// File: rtl/uart_irq_line_stat.sv
module uart_irq_line_stat #(
  parameter int unsigned CNT_W = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovr_i,
  input  logic lsr_rd_i,
  input  logic rx_wr_i,
  input  logic rx_wr_err_i,
  input  logic rx_rd_i,
  input  logic rx_rd_err_i,
  output logic pend_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             ovr_q;
  logic [CNT_W-1:0] err_cnt_q;
  logic             inc, dec;

  assign inc = rx_wr_i & rx_wr_err_i;
  assign dec = rx_rd_i & rx_rd_err_i & (err_cnt_q != '0);

  // overrun: event wins over a same-cycle status read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ovr_q <= 1'b0;
    else if (ovr_i)    ovr_q <= 1'b1;
    else if (lsr_rd_i) ovr_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_cnt_q <= '0;
    end else begin
      unique case ({inc, dec})
        2'b10:   if (err_cnt_q != CNT_MAX) err_cnt_q <= err_cnt_q + 1'b1;
        2'b01:   err_cnt_q <= err_cnt_q - 1'b1;
        default: err_cnt_q <= err_cnt_q;
      endcase
    end
  end

  assign pend_o = ovr_q | (err_cnt_q != '0);
endmodule

// File: rtl/uart_irq_idle_timer.sv
module uart_irq_idle_timer #(
  parameter int unsigned LVL_W          = 5,
  parameter int unsigned TICKS_PER_CHAR = 10,
  parameter int unsigned IDLE_CHARS     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             tick_i,
  input  logic             rx_wr_i,
  input  logic             rx_rd_i,
  input  logic [LVL_W-1:0] rx_lvl_i,
  output logic             to_o
);
  localparam int unsigned LIMIT = TICKS_PER_CHAR * IDLE_CHARS;
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             to_q;
  logic             restart;

  assign restart = rx_wr_i | rx_rd_i | ~fifo_en_i | (rx_lvl_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else if (restart) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else if (tick_i && !to_q) begin
      if (cnt_q == LAST) to_q  <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign to_o = to_q;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic       rls_i,
  input  logic       rto_i,
  input  logic       rda_i,
  input  logic       thre_i,
  output logic [3:0] iid_o
);
  iid_e code;
  always_comb begin
    if      (rls_i)  code = IID_RLS;
    else if (rto_i)  code = IID_RTO;
    else if (rda_i)  code = IID_RDA;
    else if (thre_i) code = IID_THRE;
    else             code = IID_NONE;
  end
  assign iid_o = code;
endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
  import uart_irq_pkg::*;
#(
  parameter int unsigned LVL_W          = 5,
  parameter int unsigned TICKS_PER_CHAR = 10,
  parameter int unsigned IDLE_CHARS     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             ien_rls_i,
  input  logic             ien_rda_i,
  input  logic             ien_thre_i,
  input  logic             baud_tick_i,
  input  logic             ovr_i,
  input  logic             rx_wr_i,
  input  logic             rx_wr_err_i,
  input  logic             rx_rd_i,
  input  logic             rx_rd_err_i,
  input  logic [LVL_W-1:0] rx_lvl_i,
  input  logic [LVL_W-1:0] rx_trig_i,
  input  logic             thr_empty_i,
  input  logic             thr_wr_i,
  input  logic             lsr_rd_i,
  input  logic             iir_rd_i,
  output logic [3:0]       iid_o,
  output logic             irq_o
);
  logic rls_pend, rto_pend, rda_pend;
  logic rdr_q, thre_q, thre_arm_q, thre_arm;

  uart_irq_line_stat #(.CNT_W(LVL_W)) u_line_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ovr_i       (ovr_i),
    .lsr_rd_i    (lsr_rd_i),
    .rx_wr_i     (rx_wr_i),
    .rx_wr_err_i (rx_wr_err_i),
    .rx_rd_i     (rx_rd_i),
    .rx_rd_err_i (rx_rd_err_i),
    .pend_o      (rls_pend)
  );

  uart_irq_idle_timer #(
    .LVL_W          (LVL_W),
    .TICKS_PER_CHAR (TICKS_PER_CHAR),
    .IDLE_CHARS     (IDLE_CHARS)
  ) u_idle_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fifo_en_i (fifo_en_i),
    .tick_i    (baud_tick_i),
    .rx_wr_i   (rx_wr_i),
    .rx_rd_i   (rx_rd_i),
    .rx_lvl_i  (rx_lvl_i),
    .to_o      (rto_pend)
  );

  // single-character holding flag for non-FIFO mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdr_q <= 1'b0;
    else if (rx_wr_i) rdr_q <= 1'b1;
    else if (rx_rd_i) rdr_q <= 1'b0;
  end

  assign rda_pend = fifo_en_i ? (rx_lvl_i >= rx_trig_i) : rdr_q;

  // transmit-empty: set on rising edge of enabled empty; clears win
  assign thre_arm = thr_empty_i & ien_thre_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thre_arm_q <= 1'b0;
      thre_q     <= 1'b0;
    end else begin
      thre_arm_q <= thre_arm;
      if (thr_wr_i || (iir_rd_i && iid_o == IID_THRE)) thre_q <= 1'b0;
      else if (thre_arm && !thre_arm_q)               thre_q <= 1'b1;
    end
  end

  uart_irq_prio u_prio (
    .rls_i  (rls_pend & ien_rls_i),
    .rto_i  (rto_pend & ien_rda_i),
    .rda_i  (rda_pend & ien_rda_i),
    .thre_i (thre_q & ien_thre_i),
    .iid_o  (iid_o)
  );

  assign irq_o = ~iid_o[0];
endmodule

// File: rtl/uart_irq_id_chk.sv
module uart_irq_id_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       fifo_en_i,
  input logic       ien_rls_i,
  input logic       ien_rda_i,
  input logic       ien_thre_i,
  input logic       ovr_i,
  input logic       rx_wr_i,
  input logic       rx_rd_i,
  input logic       thr_wr_i,
  input logic       iir_rd_i,
  input logic [3:0] iid_o,
  input logic       irq_o
);
  p_legal_code_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iid_o inside {4'b0001, 4'b0010, 4'b0100, 4'b0110, 4'b1100});

  p_ovr_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_i |=> (!ien_rls_i || iid_o == 4'b0110));

  p_access_clears_to_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rd_i || rx_wr_i) |=> iid_o != 4'b1100);

  p_no_to_nonfifo_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i |=> iid_o != 4'b1100);

  p_thr_wr_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_wr_i |=> iid_o != 4'b0010);

  p_iir_rd_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_rd_i && iid_o == 4'b0010) |=> iid_o != 4'b0010);

  p_all_masked_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ien_rls_i && !ien_rda_i && !ien_thre_i) |-> !irq_o);
endmodule

bind uart_irq_id uart_irq_id_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fifo_en_i  (fifo_en_i),
  .ien_rls_i  (ien_rls_i),
  .ien_rda_i  (ien_rda_i),
  .ien_thre_i (ien_thre_i),
  .ovr_i      (ovr_i),
  .rx_wr_i    (rx_wr_i),
  .rx_rd_i    (rx_rd_i),
  .thr_wr_i   (thr_wr_i),
  .iir_rd_i   (iir_rd_i),
  .iid_o      (iid_o),
  .irq_o      (irq_o)
);

// File: tb/uart_irq_id_test.sv
module uart_irq_id_test;
  localparam int LVL_W = 5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic fifo_en_i = 0, ien_rls_i = 0, ien_rda_i = 0, ien_thre_i = 0;
  logic baud_tick_i = 0, ovr_i = 0, rx_wr_i = 0, rx_wr_err_i = 0;
  logic rx_rd_i = 0, rx_rd_err_i = 0, thr_empty_i = 0, thr_wr_i = 0;
  logic lsr_rd_i = 0, iir_rd_i = 0;
  logic [LVL_W-1:0] rx_lvl_i = '0, rx_trig_i = 5'd8;
  logic [3:0] iid_o;
  logic irq_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  uart_irq_id uut (.*);

  task automatic check(input logic [3:0] exp, input string req);
    n_chk++;
    if (iid_o !== exp || irq_o !== (exp != 4'b0001)) begin
      n_bad++;
      $display("FAIL %s: iid=%b irq=%b expected iid=%b irq=%b",
               req, iid_o, irq_o, exp, exp != 4'b0001);
    end
  endtask

  task automatic step(); @(negedge clk_i); endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      baud_tick_i = 1; step(); baud_tick_i = 0; step();
    end
  endtask

  task automatic rx_write(input logic err);
    rx_wr_i = 1; rx_wr_err_i = err; step(); rx_wr_i = 0; rx_wr_err_i = 0; step();
  endtask

  task automatic rx_read(input logic err);
    rx_rd_i = 1; rx_rd_err_i = err; step(); rx_rd_i = 0; rx_rd_err_i = 0; step();
  endtask

  task automatic t_reset();
    check(4'b0001, "R1 reset");
    ien_rls_i = 1; ien_rda_i = 1; ien_thre_i = 1; step();
    check(4'b0001, "R1 enabled idle");
  endtask

  task automatic t_overrun();
    ovr_i = 1; step(); ovr_i = 0; step();
    check(4'b0110, "R2 overrun");
    lsr_rd_i = 1; step(); lsr_rd_i = 0; step();
    check(4'b0001, "R2 lsr read");
  endtask

  task automatic t_char_err();
    fifo_en_i = 1; rx_lvl_i = 5'd2;
    rx_write(1); rx_write(1);
    check(4'b0110, "R3 errored chars");
    lsr_rd_i = 1; step(); lsr_rd_i = 0; step();
    check(4'b0110, "R3 lsr read keeps");
    rx_read(1);
    check(4'b0110, "R3 one errored left");
    rx_read(1);
    check(4'b0001, "R3 all errored read");
    rx_lvl_i = '0; step();
  endtask

  task automatic t_nonfifo_rda();
    fifo_en_i = 0;
    rx_write(0);
    check(4'b0100, "R4 char ready");
    rx_read(0);
    check(4'b0001, "R4 rbr read");
  endtask

  task automatic t_fifo_rda();
    fifo_en_i = 1; rx_trig_i = 5'd4; rx_lvl_i = 5'd3; step();
    check(4'b0001, "R5 below trigger");
    rx_lvl_i = 5'd4; step();
    check(4'b0100, "R5 at trigger");
    rx_lvl_i = 5'd9; step();
    check(4'b0100, "R5 above trigger");
    rx_lvl_i = 5'd3; step();
    check(4'b0001, "R5 drops below");
    rx_lvl_i = '0; rx_trig_i = 5'd8; step();
  endtask

  task automatic t_timeout();
    fifo_en_i = 1; rx_lvl_i = 5'd2; step();
    ticks(39);
    check(4'b0001, "R6 39 ticks");
    ticks(1);
    check(4'b1100, "R6 40 ticks");
    rx_lvl_i = 5'd8; step();
    check(4'b1100, "R11 timeout over data-ready");
    rx_write(0);
    check(4'b0100, "R7 write clears timeout");
    rx_lvl_i = 5'd2; step();
    ticks(20); rx_write(0); ticks(39);
    check(4'b0001, "R7 write restarts count");
    ticks(1);
    check(4'b1100, "R7 full window after restart");
    rx_read(0);
    check(4'b0001, "R7 read clears timeout");
    rx_lvl_i = '0; step();
  endtask

  task automatic t_timeout_nonfifo();
    fifo_en_i = 0; rx_lvl_i = 5'd2; step();
    ticks(45);
    check(4'b0001, "R8 no timeout outside FIFO mode");
    rx_lvl_i = '0; fifo_en_i = 1; step();
  endtask

  task automatic t_thre();
    thr_empty_i = 1; step(); step();
    check(4'b0010, "R9 empty rise");
    thr_wr_i = 1; step(); thr_wr_i = 0; thr_empty_i = 0; step();
    check(4'b0001, "R9 thr write clears");
    thr_empty_i = 1; step(); step();
    iir_rd_i = 1; step(); iir_rd_i = 0; step();
    check(4'b0001, "R10 iir read clears");
    thr_empty_i = 0; step(); thr_empty_i = 1; step(); step();
    ovr_i = 1; step(); ovr_i = 0; step();
    check(4'b0110, "R11 line status over thre");
    iir_rd_i = 1; step(); iir_rd_i = 0; step();
    lsr_rd_i = 1; step(); lsr_rd_i = 0; step();
    check(4'b0010, "R10 iir read under other code keeps");
  endtask

  task automatic t_mask();
    rx_trig_i = 5'd4; rx_lvl_i = 5'd5; step();
    check(4'b0100, "R11 data-ready over thre");
    ien_rda_i = 0; step();
    check(4'b0010, "R12 data-ready masked");
    ien_thre_i = 0; step();
    check(4'b0001, "R12 all masked irq low");
    rx_lvl_i = '0; step();
  endtask

  initial begin
    repeat (3) step();
    rst_ni = 1; step();
    t_reset();
    t_overrun();
    t_char_err();
    t_nonfifo_rda();
    t_fifo_rda();
    t_timeout();
    t_timeout_nonfifo();
    t_thre();
    t_mask();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule